// File: doc/BRIEF.md
# Drive Control-Line Sequencer

This block sits between a host register port and the control bus of a floppy drive. The drive exposes sixteen internal registers, addressed by four lines. Three of them are phase lines driven from a select register. The fourth is a head-select line driven from bit 5 of an eight-bit control register. The control register has no direct write address. Instead, one write address ORs the written byte into it and another clears every bit that is one in the written byte. The other control bits are handed on unchanged to neighbouring logic.

A write to the select register starts a timed sequence. The phase lines first park for one cycle at the relax code 3. They then take the new address and hold it for one microsecond. If the write has bit 3 set, this is a drive command (for example motor on, eject, or a step). For a command, a latch strobe then rises for two microseconds and falls, followed by one microsecond of hold. If bit 3 is clear, the write only selects a sense register, and no strobe is issued. The drive reports the selected sense register on one active-low input, which the host reads as bit 3 of the status byte.

All intervals are counted in clock cycles from the parameter `CYC_PER_US`, so they are exact at any clock rate. A busy flag covers the whole sequence, and select writes that arrive while it is high are dropped.

Top module: `drive_line_ctl`

## Requirements
- R1: After reset the phase lines read 3 (relax), the strobe and busy are low, and the control register is 0x00.
- R2: A write to address 1 ORs the data into the control register. A write to address 2 clears the bits that are one in the data. Output `hsel_o` always equals control bit 5, the fourth drive address bit.
- R3: On the first cycle after an accepted write to address 0, the phase lines show 3. On the next cycle they show data bits [2:0].
- R4: When data bit 3 is set, the new address is held for exactly `CYC_PER_US` cycles before the strobe rises, and it does not change while the strobe is high.
- R5: The strobe stays high for exactly 2×`CYC_PER_US` cycles per command, and it pulses once.
- R6: After the strobe falls, busy stays high for exactly `CYC_PER_US` further cycles and then drops. The phase lines keep the address.
- R7: When data bit 3 is clear, no strobe is produced. Busy drops after the `CYC_PER_US` address-setup cycles.
- R8: A write to address 0 while busy is high is ignored. The running sequence keeps its address, timing and single pulse.
- R9: Status bit 3 (mask 0x08) is the sense input as seen two cycles earlier, where low means the sensed condition is true. All other status bits read 0.
- R10: Busy is high from the cycle after an accepted select write until the sequence ends, and the strobe is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | 0 select, 1 control set, 2 control clear |
| reg_wdata | input | 8 | Write data |
| sense_n | input | 1 | Drive sense line, low = true |
| phase_o | output | 3 | Drive phase lines |
| hsel_o | output | 1 | Fourth drive address bit (control bit 5) |
| strobe_o | output | 1 | Drive latch strobe |
| busy_o | output | 1 | Sequence in progress |
| ctrl_o | output | 8 | Control register contents |
| status_o | output | 8 | Status byte, bit 3 = sense |

## Verification
The bench measures the setup, strobe and hold windows by counting cycles. An off-by-one in the prescaler reload would show up as a setup, pulse or hold window one cycle long or short. The bench also checks the relax park cycle; a design that skips it would put a glitch address onto the bus. A select write fired into the middle of a strobe must leave the address and the pulse width untouched; a design that accepts it would retarget the drive mid-command. The bench also covers the clear alias, which a design could wrongly treat as a plain write, and the two-cycle latency and low-true polarity of the sense bit.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PARK, SQ_SETUP, SQ_STRB, SQ_HOLD
  } sq_state_t;

  localparam logic [1:0] A_SEL  = 2'd0;
  localparam logic [1:0] A_CSET = 2'd1;
  localparam logic [1:0] A_CCLR = 2'd2;

  localparam logic [2:0] RELAX_PH    = 3'd3;
  localparam int         HSEL_BIT    = 5;
  localparam int         STRB_REQ_BIT = 3;
  localparam int         SENSE_BIT   = 3;

  // cycles making up n microseconds
  function automatic int us_cycles(input int n_us, input int cyc_per_us);
    return n_us * cyc_per_us;
  endfunction

  // next control register value for a write through one of its aliases
  function automatic logic [7:0] ctrl_next(input logic [7:0] cur,
                                           input logic [1:0] addr,
                                           input logic [7:0] wdata);
    case (addr)
      A_CSET:  return cur | wdata;
      A_CCLR:  return cur & ~wdata;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/dlc_tick_timer.sv
module dlc_tick_timer #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] len,
  output logic          expired
);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (load)             cnt_q <= len - LW'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - LW'(1);
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dlc_strobe_seq.sv
module dlc_strobe_seq
  import dlc_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int LW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sel,
  input  logic [3:0] sel_data,
  output logic [2:0] phase_o,
  output logic       strobe_o,
  output logic       busy_o
);
  localparam logic [LW-1:0] LEN_SETUP = LW'(us_cycles(1, CYC_PER_US));
  localparam logic [LW-1:0] LEN_STRB  = LW'(us_cycles(2, CYC_PER_US));
  localparam logic [LW-1:0] LEN_HOLD  = LW'(us_cycles(1, CYC_PER_US));

  sq_state_t     st_q;
  logic [2:0]    tgt_q;
  logic          want_strb_q;
  logic [2:0]    ph_q;
  logic          strb_q;
  logic          sel_accept;
  logic          tmr_load;
  logic [LW-1:0] tmr_len;
  logic          tmr_expired;

  assign busy_o     = (st_q != SQ_IDLE);
  assign sel_accept = wr_sel && !busy_o;

  always_comb begin
    tmr_load = 1'b0;
    tmr_len  = LEN_SETUP;
    case (st_q)
      SQ_PARK:  begin tmr_load = 1'b1; tmr_len = LEN_SETUP; end
      SQ_SETUP: begin tmr_load = tmr_expired && want_strb_q; tmr_len = LEN_STRB; end
      SQ_STRB:  begin tmr_load = tmr_expired; tmr_len = LEN_HOLD; end
      default:  ;
    endcase
  end

  dlc_tick_timer #(.LW(LW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expired(tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= SQ_IDLE;
      tgt_q       <= RELAX_PH;
      want_strb_q <= 1'b0;
      ph_q        <= RELAX_PH;
      strb_q      <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: if (sel_accept) begin
          st_q        <= SQ_PARK;
          ph_q        <= RELAX_PH;
          tgt_q       <= sel_data[2:0];
          want_strb_q <= sel_data[STRB_REQ_BIT];
        end
        SQ_PARK: begin
          st_q <= SQ_SETUP;
          ph_q <= tgt_q;
        end
        SQ_SETUP: if (tmr_expired) begin
          if (want_strb_q) begin
            st_q   <= SQ_STRB;
            strb_q <= 1'b1;
          end else begin
            st_q <= SQ_IDLE;
          end
        end
        SQ_STRB: if (tmr_expired) begin
          st_q   <= SQ_HOLD;
          strb_q <= 1'b0;
        end
        SQ_HOLD: if (tmr_expired) st_q <= SQ_IDLE;
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign phase_o  = ph_q;
  assign strobe_o = strb_q;

  // R10
  strb_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> busy_o);
  // R4
  addr_before_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_o) |-> $stable(phase_o));
  // R6
  hold_after_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> busy_o);
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && wr_sel) |=> $stable(tgt_q));
endmodule

// File: rtl/dlc_ctrl_reg.sv
module dlc_ctrl_reg
  import dlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] ctrl_o
);
  logic [7:0] ctrl_q;
  logic       wr_set;
  logic       wr_clr;

  assign wr_set = reg_wr && (reg_addr == A_CSET);
  assign wr_clr = reg_wr && (reg_addr == A_CCLR);

  always_ff @(posedge clk) begin
    if (!rst_n)                ctrl_q <= 8'h00;
    else if (wr_set || wr_clr) ctrl_q <= ctrl_next(ctrl_q, reg_addr, reg_wdata);
  end

  assign ctrl_o = ctrl_q;

  // R2
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((ctrl_o & $past(reg_wdata)) == $past(reg_wdata)));
  // R2
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((ctrl_o & $past(reg_wdata)) == 8'h00));
endmodule

// File: rtl/dlc_sense_sync.sv
module dlc_sense_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_n,
  output logic sense_q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= sense_n;
      s2_q <= s1_q;
    end
  end

  assign sense_q = s2_q;
endmodule

// File: rtl/drive_line_ctl.sv
module drive_line_ctl
  import dlc_pkg::*;
#(
  parameter int CYC_PER_US = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       sense_n,
  output logic [2:0] phase_o,
  output logic       hsel_o,
  output logic       strobe_o,
  output logic       busy_o,
  output logic [7:0] ctrl_o,
  output logic [7:0] status_o
);
  localparam int LW = $clog2(2 * CYC_PER_US + 1) + 1;

  logic wr_sel;
  logic sense_q;

  assign wr_sel = reg_wr && (reg_addr == A_SEL);

  dlc_strobe_seq #(.CYC_PER_US(CYC_PER_US), .LW(LW)) seq_i (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .sel_data(reg_wdata[3:0]),
    .phase_o(phase_o), .strobe_o(strobe_o), .busy_o(busy_o)
  );

  dlc_ctrl_reg ctrl_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ctrl_o(ctrl_o)
  );

  dlc_sense_sync sync_i (
    .clk(clk), .rst_n(rst_n), .sense_n(sense_n), .sense_q(sense_q)
  );

  assign hsel_o = ctrl_o[HSEL_BIT];

  always_comb begin
    status_o            = 8'h00;
    status_o[SENSE_BIT] = sense_q;
  end
endmodule

// File: tb/drive_line_ctl_tb_top.sv
module drive_line_ctl_tb_top;
  localparam int CYC = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic       sense_n = 1'b1;
  logic [2:0] phase_o;
  logic       hsel_o, strobe_o, busy_o;
  logic [7:0] ctrl_o, status_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  drive_line_ctl #(.CYC_PER_US(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sense_n(sense_n), .phase_o(phase_o),
    .hsel_o(hsel_o), .strobe_o(strobe_o), .busy_o(busy_o),
    .ctrl_o(ctrl_o), .status_o(status_o)
  );

  // {is_command, 4-bit drive address}
  localparam logic [4:0] VEC [6] = '{
    {1'b1, 4'd0},  // step direction positive
    {1'b1, 4'd4},  // step direction negative
    {1'b1, 4'd7},  // eject
    {1'b1, 4'd9},  // select MFM
    {1'b1, 4'd13}, // select GCR
    {1'b0, 4'd10}  // sense track zero
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run_seq(input logic [3:0] code, input bit is_cmd, input bit poke);
    int n;
    int pulses;
    if (code[3]) wr(2'd1, 8'h20); else wr(2'd2, 8'h20);
    check(hsel_o == code[3], "R2 hsel", hsel_o, code[3]);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = {4'h0, is_cmd, code[2:0]};
    @(negedge clk);
    reg_wr = 1'b0;
    check(phase_o == 3'd3 && busy_o, "R3 park", phase_o, 3);
    check(busy_o == 1'b1, "R10 busy", busy_o, 1);
    @(negedge clk);
    check(phase_o == code[2:0], "R3 addr", phase_o, code[2:0]);
    n = 0;
    while (busy_o && !strobe_o && n < 10*CYC) begin
      n++;
      if (phase_o != code[2:0]) check(0, "R4 addr stable", phase_o, code[2:0]);
      @(negedge clk);
    end
    check(n == CYC, is_cmd ? "R4 setup" : "R7 setup", n, CYC);
    if (is_cmd) begin
      n = 0;
      while (strobe_o && n < 10*CYC) begin
        n++;
        if (phase_o != code[2:0] || hsel_o != code[3])
          check(0, "R4 addr during strobe", {hsel_o, phase_o}, code);
        if (poke && n == 5) begin
          reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h0E;
        end else begin
          reg_wr = 1'b0;
        end
        @(negedge clk);
      end
      reg_wr = 1'b0;
      check(n == 2*CYC, poke ? "R8 width" : "R5 width", n, 2*CYC);
      n = 0;
      pulses = 0;
      while (busy_o && n < 10*CYC) begin
        n++;
        if (strobe_o) pulses++;
        @(negedge clk);
      end
      check(n == CYC && pulses == 0, poke ? "R8 hold" : "R6 hold", n, CYC);
      check(phase_o == code[2:0], poke ? "R8 addr kept" : "R6 addr kept", phase_o, code[2:0]);
    end else begin
      check(!strobe_o && !busy_o, "R7 no strobe", strobe_o, 0);
      check(phase_o == code[2:0], "R7 addr", phase_o, code[2:0]);
    end
    repeat (3) @(negedge clk);
    check(!busy_o && !strobe_o, "R10 idle", busy_o, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check(phase_o == 3'd3, "R1 phase", phase_o, 3);
    check(!strobe_o && !busy_o, "R1 strobe/busy", {strobe_o, busy_o}, 0);
    check(ctrl_o == 8'h00, "R1 ctrl", ctrl_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 alias behaviour
    wr(2'd1, 8'hA5);
    check(ctrl_o == 8'hA5, "R2 set", ctrl_o, 8'hA5);
    wr(2'd2, 8'h81);
    check(ctrl_o == 8'h24, "R2 clear", ctrl_o, 8'h24);
    check(hsel_o == 1'b1, "R2 hsel bit5", hsel_o, 1);
    wr(2'd1, 8'h02);
    check(ctrl_o == 8'h26, "R2 set keeps", ctrl_o, 8'h26);
    wr(2'd2, 8'h20);
    check(hsel_o == 1'b0 && ctrl_o == 8'h06, "R2 clear bit5", ctrl_o, 8'h06);

    // table-driven sequences: R3 R4 R5 R6 R7
    for (int i = 0; i < 6; i++) run_seq(VEC[i][3:0], VEC[i][4], 1'b0);

    // R8 select write during the strobe is ignored
    run_seq(4'd2, 1'b1, 1'b1);

    // R9 sense path: two-cycle latency, low = true
    check(status_o == 8'h08, "R9 idle high", status_o, 8'h08);
    sense_n = 1'b0;
    @(negedge clk);
    check(status_o == 8'h08, "R9 latency", status_o, 8'h08);
    @(negedge clk);
    check(status_o == 8'h00, "R9 true low", status_o, 8'h00);
    sense_n = 1'b1;
    repeat (2) @(negedge clk);
    check(status_o == 8'h08, "R9 release", status_o, 8'h08);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule